// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block joins two parallel buses, A and B, through per-direction holding stages. The bus is split into byte-wide lanes with fully separate controls. Each lane has two paths, one from A to B and one from B to A. Each path has three active-low controls: a select, a capture gate and a drive enable.

While a path's select and capture gate are both low, its stage is open. Input data then flows straight through to the far side in the same cycle. When the capture gate goes high with select low, the stage keeps the last value that was sampled while it was open. With select high, the stage keeps its contents whatever the capture gate does, and the path drives nothing.

Each port is split into separate input, output and per-bit output-enable vectors, so the tri-state pad can sit outside the block. The stored value is sampled on every rising clock edge while the stage is open. The open path itself is combinational, so data passes through in the same cycle.

Top module: `xcvr_latched_bus`

## Requirements
- R1: After reset every stored value in both directions of every lane is zero. Selecting a path with its capture gate high and its drive enable low then presents 0x00.
- R2: When select, capture gate and drive enable of a path are all low, the far port output equals the near port input in the same cycle.
- R3: If the capture gate rises while select stays low, the path keeps presenting the value sampled at the last clock edge before the rise, and later changes on the near input have no effect.
- R4: While select is high, the stored value is not updated, whatever the capture gate and input do. The far port output-enable is low.
- R5: While drive enable is high, the far port is not driven, but the stage still captures when select and capture gate are both low. That value appears once drive is re-enabled.
- R6: Each bit of a port's output-enable vector is 1 exactly when that path's select and drive enable are both low.
- R7: The B-to-A path obeys R2 to R6 with its own three controls, independently of the A-to-B path.
- R8: Each lane reacts only to its own six controls. A control on one lane leaves the other lane's outputs and stored values unchanged.
- R9: Whenever a path is not driving, its data output vector is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the holding stages |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | N_LANES*LANE_W | A port input data |
| b_i | input | N_LANES*LANE_W | B port input data |
| sel_ab_ni | input | N_LANES | A-to-B select, active low, per lane |
| cap_ab_ni | input | N_LANES | A-to-B capture gate, active low, per lane |
| drv_ab_ni | input | N_LANES | A-to-B drive enable, active low, per lane |
| sel_ba_ni | input | N_LANES | B-to-A select, active low, per lane |
| cap_ba_ni | input | N_LANES | B-to-A capture gate, active low, per lane |
| drv_ba_ni | input | N_LANES | B-to-A drive enable, active low, per lane |
| b_o | output | N_LANES*LANE_W | Data driven toward the B port |
| b_oe_o | output | N_LANES*LANE_W | Per-bit B port output enable |
| a_o | output | N_LANES*LANE_W | Data driven toward the A port |
| a_oe_o | output | N_LANES*LANE_W | Per-bit A port output enable |

## Verification
Output-enable, flow-through and disabled-zero results appear in the same cycle as the control or data change. The bench drives inputs just after the falling edge and checks two time units later, before the next rising edge. A stored value changes only at a rising edge while the stage is open. The bench model updates its copy at that same edge, so a capture shows up at the first check after the edge. The capture-gate rise of R3 therefore exposes the value from the edge before the rise, and the bench expects exactly that.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_LANE_W  = 8;
  localparam int unsigned DEF_N_LANES = 2;

  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic drv_n;
  } path_ctrl_t;
endpackage

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int unsigned W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        d_i,
  input  xcvr_pkg::path_ctrl_t ctrl_i,
  output logic [W-1:0]        q_o,
  output logic [W-1:0]        oe_o
);
  logic         open;
  logic         drive;
  logic [W-1:0] store_q;
  logic [W-1:0] data;

  assign open  = !ctrl_i.sel_n && !ctrl_i.cap_n;
  assign drive = !ctrl_i.sel_n && !ctrl_i.drv_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= '0;
    else if (open) store_q <= d_i;
  end

  assign data = open ? d_i : store_q;
  assign q_o  = drive ? data : '0;
  assign oe_o = {W{drive}};

  p_flow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.sel_n && !ctrl_i.cap_n && !ctrl_i.drv_n) |-> (q_o == d_i));

  p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.sel_n && !ctrl_i.cap_n) ##1 (!ctrl_i.sel_n && ctrl_i.cap_n && !ctrl_i.drv_n)
    |-> (q_o == $past(d_i)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.sel_n |=> $stable(store_q));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o == '0) |-> (q_o == '0));

  p_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.sel_n || ctrl_i.drv_n) |-> (oe_o == '0));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  xcvr_pkg::path_ctrl_t ab_ctrl_i,
  input  xcvr_pkg::path_ctrl_t ba_ctrl_i,
  output logic [W-1:0]         b_o,
  output logic [W-1:0]         b_oe_o,
  output logic [W-1:0]         a_o,
  output logic [W-1:0]         a_oe_o
);
  xcvr_path #(.W(W)) i_ab (
    .clk_i, .rst_ni, .d_i(a_i), .ctrl_i(ab_ctrl_i), .q_o(b_o), .oe_o(b_oe_o)
  );

  xcvr_path #(.W(W)) i_ba (
    .clk_i, .rst_ni, .d_i(b_i), .ctrl_i(ba_ctrl_i), .q_o(a_o), .oe_o(a_oe_o)
  );

  p_split_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_ctrl_i.sel_n |-> (a_oe_o == '0));
endmodule

// File: rtl/xcvr_latched_bus.sv
module xcvr_latched_bus #(
  parameter int unsigned LANE_W  = xcvr_pkg::DEF_LANE_W,
  parameter int unsigned N_LANES = xcvr_pkg::DEF_N_LANES,
  localparam int unsigned BUS_W  = LANE_W * N_LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BUS_W-1:0]   a_i,
  input  logic [BUS_W-1:0]   b_i,
  input  logic [N_LANES-1:0] sel_ab_ni,
  input  logic [N_LANES-1:0] cap_ab_ni,
  input  logic [N_LANES-1:0] drv_ab_ni,
  input  logic [N_LANES-1:0] sel_ba_ni,
  input  logic [N_LANES-1:0] cap_ba_ni,
  input  logic [N_LANES-1:0] drv_ba_ni,
  output logic [BUS_W-1:0]   b_o,
  output logic [BUS_W-1:0]   b_oe_o,
  output logic [BUS_W-1:0]   a_o,
  output logic [BUS_W-1:0]   a_oe_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    xcvr_pkg::path_ctrl_t ab_ctrl, ba_ctrl;
    assign ab_ctrl = '{sel_n: sel_ab_ni[l], cap_n: cap_ab_ni[l], drv_n: drv_ab_ni[l]};
    assign ba_ctrl = '{sel_n: sel_ba_ni[l], cap_n: cap_ba_ni[l], drv_n: drv_ba_ni[l]};

    xcvr_lane #(.W(LANE_W)) i_lane (
      .clk_i,
      .rst_ni,
      .a_i      (a_i[l*LANE_W +: LANE_W]),
      .b_i      (b_i[l*LANE_W +: LANE_W]),
      .ab_ctrl_i(ab_ctrl),
      .ba_ctrl_i(ba_ctrl),
      .b_o      (b_o[l*LANE_W +: LANE_W]),
      .b_oe_o   (b_oe_o[l*LANE_W +: LANE_W]),
      .a_o      (a_o[l*LANE_W +: LANE_W]),
      .a_oe_o   (a_oe_o[l*LANE_W +: LANE_W])
    );

    // lane isolation: a lane's B enable follows only its own controls
    p_lane_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_ab_ni[l] || drv_ab_ni[l]) |-> (b_oe_o[l*LANE_W +: LANE_W] == '0));
  end
endmodule

// File: tb/test_xcvr_latched_bus.sv
module test_xcvr_latched_bus;
  localparam int W = 8;
  localparam int NL = 2;
  localparam int BW = W * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] a_i = '0, b_i = '0;
  logic [NL-1:0] sel_ab = '1, cap_ab = '1, drv_ab = '1;
  logic [NL-1:0] sel_ba = '1, cap_ba = '1, drv_ba = '1;
  logic [BW-1:0] b_o, b_oe, a_o, a_oe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_ab [NL];
  logic [W-1:0] m_ba [NL];

  always #5 clk = ~clk;

  xcvr_latched_bus #(.LANE_W(W), .N_LANES(NL)) i_xcvr_latched_bus (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_i), .b_i(b_i),
    .sel_ab_ni(sel_ab), .cap_ab_ni(cap_ab), .drv_ab_ni(drv_ab),
    .sel_ba_ni(sel_ba), .cap_ba_ni(cap_ba), .drv_ba_ni(drv_ba),
    .b_o(b_o), .b_oe_o(b_oe), .a_o(a_o), .a_oe_o(a_oe)
  );

  // reference model of stored values
  always @(posedge clk or negedge rst_n) begin
    for (int l = 0; l < NL; l++) begin
      if (!rst_n) begin
        m_ab[l] <= '0; m_ba[l] <= '0;
      end else begin
        if (!sel_ab[l] && !cap_ab[l]) m_ab[l] <= a_i[l*W +: W];
        if (!sel_ba[l] && !cap_ba[l]) m_ba[l] <= b_i[l*W +: W];
      end
    end
  end

  function automatic logic [W-1:0] exp_data(logic s, logic c, logic d,
                                            logic [W-1:0] din, logic [W-1:0] st);
    if (s || d) return '0;
    return c ? st : din;
  endfunction

  function automatic string tag_of(logic s, logic c, logic d);
    if (s) return "R4";
    if (d) return "R5";
    return c ? "R3" : "R2";
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // full check of every lane, both directions
  task automatic check_all(string extra);
    for (int l = 0; l < NL; l++) begin
      chk({tag_of(sel_ab[l], cap_ab[l], drv_ab[l]), " ab ", extra}, b_o[l*W +: W],
          exp_data(sel_ab[l], cap_ab[l], drv_ab[l], a_i[l*W +: W], m_ab[l]));
      chk({"R6 ab oe ", extra}, b_oe[l*W +: W], {W{!sel_ab[l] && !drv_ab[l]}});
      chk({"R7 ba ", tag_of(sel_ba[l], cap_ba[l], drv_ba[l]), " ", extra}, a_o[l*W +: W],
          exp_data(sel_ba[l], cap_ba[l], drv_ba[l], b_i[l*W +: W], m_ba[l]));
      chk({"R7 R6 ba oe ", extra}, a_oe[l*W +: W], {W{!sel_ba[l] && !drv_ba[l]}});
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: reset contents read back as zero
    sel_ab = '0; drv_ab = '0; sel_ba = '0; drv_ba = '0; a_i = '1; b_i = '1;
    #2;
    chk("R1 ab", b_o, '0);
    chk("R1 ba", a_o, '0);

    // R2 flow-through, R3 keep after capture rise
    step(); cap_ab = '0; a_i = 16'hA55A; #2;
    chk("R2 flow", b_o, 16'hA55A);
    step(); cap_ab = '1; a_i = 16'hFFFF; #2;
    chk("R3 keep", b_o, 16'hA55A);
    step(); a_i = 16'h0101; #2;
    chk("R3 ignore input", b_o, 16'hA55A);

    // R4: select high blocks load and drive
    step(); sel_ab = '1; cap_ab = '0; a_i = 16'h7777; #2;
    chk("R4 oe off", b_oe, '0);
    chk("R9 zero", b_o, '0);
    step(); sel_ab = '0; cap_ab = '1; #2;
    chk("R4 held", b_o, 16'hA55A);

    // R5: capture with drive off, then re-enable
    step(); drv_ab = '1; cap_ab = '0; a_i = 16'h3C33; #2;
    chk("R5 not driven", b_oe, '0);
    step(); cap_ab = '1; a_i = '0; #2;
    step(); drv_ab = '0; #2;
    chk("R5 captured", b_o, 16'h3C33);

    // R8: lane 0 open, lane 1 stored
    step(); cap_ab = 2'b10; a_i = 16'h9966; #2;
    chk("R8 lanes", b_o, 16'h3C66);

    // R7 directed B-to-A capture
    step(); cap_ba = '0; b_i = 16'h1234; #2;
    chk("R7 flow", a_o, 16'h1234);
    step(); cap_ba = '1; b_i = 16'h0000; #2;
    chk("R7 keep", a_o, 16'h1234);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      step();
      a_i = BW'($urandom); b_i = BW'($urandom);
      sel_ab = NL'($urandom); cap_ab = NL'($urandom); drv_ab = NL'($urandom);
      sel_ba = NL'($urandom); cap_ba = NL'($urandom); drv_ba = NL'($urandom);
      #2;
      check_all("rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule